// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block is the device-side front end of a parallel NAND flash bus. On every write strobe it samples the 8-bit bus. The active-low chip select and the two latch qualifiers decide whether the byte is an opcode, an address byte or plain data. Opcodes move a small state machine between read, program, erase, read-ID, status, copy-back and "other" states. Address bytes are packed into a wide address register. The block then emits a one-cycle operation pulse that carries an operation code and an address, and the page store and output path that follow act on that pulse.

Three parameters set the geometry: `LARGE_PAGE` (two-byte column, start on a later cycle), `BIG_DEVICE` (large-page parts of 2 Gbit and up) and `WIDE_BUS` (16-bit data bus). Together they choose the address cycle on which a read or a program setup fires, the shift applied when an erase row is formed, and whether the column is turned into a byte address. The read variants 0x01 and 0x50 become a plain read, with a preset starting column offset.

States (output `cmd_state`): ST_READ=0, ST_PROGRAM=1, ST_ERASE=2, ST_READ_ID=3, ST_STATUS=4, ST_COPYBACK=5, ST_OTHER=6. Transitions happen only on an accepted opcode:
- 0x00/0x01/0x50 go to ST_READ.
- 0x80 goes to ST_PROGRAM.
- 0x60 goes to ST_ERASE.
- 0x90 goes to ST_READ_ID.
- 0x70 goes to ST_STATUS.
- 0x85 goes to ST_COPYBACK.
- 0xFF goes to ST_READ.
- 0x10, 0xD0, 0x15, 0x35, 0xE0, an unrecognised byte, and 0x30 or 0x05 when they are not special-cased all go to ST_OTHER.
- In large-page mode, 0x30 seen in ST_READ and 0x05 in any state leave the state where it is.

Top module: `nand_cmd_seq`

## Requirements
- R1: A strobe while `chip_sel_n` is high changes nothing: the state, address count and column offset keep their values and no operation pulse follows.
- R2: A strobe with `chip_sel_n` low and `cmd_latch` high is an opcode, even if `addr_latch` is also high. The state encoding is the one listed above (read 0, program 1, erase 2, ID 3, status 4, copy-back 5, other 6).
- R3: Opcodes 0x00, 0x01 and 0x50 all enter ST_READ and set `col_offset` to 0, 0x100 and PAGE_BYTES respectively. Other opcodes leave the offset unchanged, except reset.
- R4: In large-page mode, opcode 0x30 received in ST_READ is ignored: state, count and address stay as they were and no pulse follows.
- R5: In large-page mode, opcode 0x05 clears the low 16 address bits and the address count and leaves the state unchanged.
- R6: An address strobe (`addr_latch` high, `cmd_latch` low) writes the byte at bit 8×count and increments the count. The count saturates at ADDR_BYTES and further bytes are dropped. Every opcode except 0xE0 clears the count.
- R7: Operation codes on `op_kind`: 1 load, 2 program setup, 3 program, 4 erase, 5 status, 6 read ID, 7 reset. Opcode 0x70 pulses 5 and 0x10 pulses 3, both carrying the current address. In large-page mode, 0x35 and 0xE0 pulse 1 with the current address.
- R8: In ST_READ_ID, the first address byte pulses 6, carrying the address with that byte included.
- R9: In ST_READ (pulse 1) or ST_PROGRAM (pulse 2), the address byte that brings the count to the start cycle fires the pulse with the full address. The start cycle is 3 for small pages, 4 for large pages of 1 Gbit or less, and 5 for large pages of 2 Gbit or more.
- R10: With `WIDE_BUS`, the address is shifted left by one bit right after the second address byte is written.
- R11: Opcode 0xD0 masks the address to the bytes received since the last count clear. It then shifts the result left by 16 bits (large page) or 8 bits (small page), stores it, and pulses 4 with it.
- R12: Opcode 0xFF enters ST_READ, clears the address, count and offset, and pulses 7 with address 0.
- R13: `op_valid` is high only in the single cycle after an accepted strobe that fires an operation. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | One-cycle write strobe, synchronous to clk |
| chip_sel_n | input | 1 | Active-low chip select |
| cmd_latch | input | 1 | Marks the byte as an opcode |
| addr_latch | input | 1 | Marks the byte as an address byte |
| bus_in | input | 8 | Data bus byte |
| op_valid | output | 1 | Operation start pulse |
| op_kind | output | 3 | Operation code for the pulse |
| op_addr | output | 8×ADDR_BYTES | Address carried with the pulse |
| col_offset | output | clog2(PAGE_BYTES)+1 | Preset starting column offset |
| cmd_state | output | 3 | Current command state |
| addr_count | output | clog2(ADDR_BYTES+1) | Address bytes collected |

## Verification
Every result is registered on the clock edge that samples the strobe. The state, count, offset and operation pulse are therefore all due exactly one cycle after the strobe cycle. The bench raises the strobe on a falling edge, drops it on the next falling edge, and reads every output at that second falling edge, half a period after the update. The pulse is then high only for that single sample. Three instances with different geometry share the stimulus, so the first, third, fourth and fifth address byte can each be checked as the firing cycle, alongside the cycles that must stay silent.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        ST_READ     = 3'd0,
        ST_PROGRAM  = 3'd1,
        ST_ERASE    = 3'd2,
        ST_READ_ID  = 3'd3,
        ST_STATUS   = 3'd4,
        ST_COPYBACK = 3'd5,
        ST_OTHER    = 3'd6
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_LOAD       = 3'd1,
        OP_PROG_SETUP = 3'd2,
        OP_PROGRAM    = 3'd3,
        OP_ERASE      = 3'd4,
        OP_STATUS     = 3'd5,
        OP_ID         = 3'd6,
        OP_RESET      = 3'd7
    } op_kind_e;

    typedef enum logic [4:0] {
        CL_READ_A, CL_READ_B, CL_READ_C, CL_READ_CONFIRM, CL_NOSER_CONFIRM,
        CL_RAND_COL, CL_RAND_CONFIRM, CL_READ_ID, CL_RESET, CL_PROG_SETUP,
        CL_PROG_CONFIRM, CL_CACHE_CONFIRM, CL_ERASE_SETUP, CL_ERASE_CONFIRM,
        CL_STATUS, CL_COPYBACK, CL_UNKNOWN
    } cmd_class_e;

    localparam logic [7:0] OPC_READ_A        = 8'h00;
    localparam logic [7:0] OPC_READ_B        = 8'h01;
    localparam logic [7:0] OPC_READ_C        = 8'h50;
    localparam logic [7:0] OPC_READ_CONFIRM  = 8'h30;
    localparam logic [7:0] OPC_NOSER_CONFIRM = 8'h35;
    localparam logic [7:0] OPC_RAND_COL      = 8'h05;
    localparam logic [7:0] OPC_RAND_CONFIRM  = 8'hE0;
    localparam logic [7:0] OPC_READ_ID       = 8'h90;
    localparam logic [7:0] OPC_RESET         = 8'hFF;
    localparam logic [7:0] OPC_PROG_SETUP    = 8'h80;
    localparam logic [7:0] OPC_PROG_CONFIRM  = 8'h10;
    localparam logic [7:0] OPC_CACHE_CONFIRM = 8'h15;
    localparam logic [7:0] OPC_ERASE_SETUP   = 8'h60;
    localparam logic [7:0] OPC_ERASE_CONFIRM = 8'hD0;
    localparam logic [7:0] OPC_STATUS        = 8'h70;
    localparam logic [7:0] OPC_COPYBACK      = 8'h85;

endpackage

// File: rtl/nand_opcode_decode.sv
module nand_opcode_decode
    import nand_seq_pkg::*;
(
    input  logic [7:0]  opcode,
    output cmd_class_e  cls
);
    always_comb begin
        unique case (opcode)
            OPC_READ_A:        cls = CL_READ_A;
            OPC_READ_B:        cls = CL_READ_B;
            OPC_READ_C:        cls = CL_READ_C;
            OPC_READ_CONFIRM:  cls = CL_READ_CONFIRM;
            OPC_NOSER_CONFIRM: cls = CL_NOSER_CONFIRM;
            OPC_RAND_COL:      cls = CL_RAND_COL;
            OPC_RAND_CONFIRM:  cls = CL_RAND_CONFIRM;
            OPC_READ_ID:       cls = CL_READ_ID;
            OPC_RESET:         cls = CL_RESET;
            OPC_PROG_SETUP:    cls = CL_PROG_SETUP;
            OPC_PROG_CONFIRM:  cls = CL_PROG_CONFIRM;
            OPC_CACHE_CONFIRM: cls = CL_CACHE_CONFIRM;
            OPC_ERASE_SETUP:   cls = CL_ERASE_SETUP;
            OPC_ERASE_CONFIRM: cls = CL_ERASE_CONFIRM;
            OPC_STATUS:        cls = CL_STATUS;
            OPC_COPYBACK:      cls = CL_COPYBACK;
            default:           cls = CL_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/nand_addr_reg.sv
module nand_addr_reg #(
    parameter int ADDR_BYTES = 5,
    parameter int COL_BITS   = 16,
    parameter int ROW_SHIFT  = 16,
    parameter bit WIDE_BUS   = 1'b0,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_col,
    input  logic              clr_cnt,
    input  logic              erase_fix,
    input  logic              byte_en,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_nx,
    output logic [CNT_W-1:0]  cnt_q
);
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        addr_nx = addr_q;
        cnt_nx  = cnt_q;
        if (clr_all) begin
            addr_nx = '0;
            cnt_nx  = '0;
        end else if (clr_col) begin
            addr_nx[COL_BITS-1:0] = '0;
            cnt_nx = '0;
        end else if (erase_fix) begin
            for (int i = 0; i < ADDR_BYTES; i++) begin
                if (i >= int'(cnt_q)) addr_nx[i*8 +: 8] = 8'h00;
            end
            addr_nx = addr_nx << ROW_SHIFT;
            cnt_nx  = '0;
        end else if (clr_cnt) begin
            cnt_nx = '0;
        end else if (byte_en && (cnt_q < CNT_W'(ADDR_BYTES))) begin
            addr_nx[int'(cnt_q)*8 +: 8] = byte_in;
            cnt_nx = cnt_q + 1'b1;
            if (WIDE_BUS && (cnt_nx == CNT_W'(2))) addr_nx = addr_nx << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_nx;
            cnt_q  <= cnt_nx;
        end
    end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter bit LARGE_PAGE  = 1'b1,
    parameter int ADDR_BYTES  = 5,
    parameter int PAGE_BYTES  = 2048,
    parameter int START_CYC   = 4,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1),
    localparam int OFF_W      = $clog2(PAGE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic              chip_sel_n,
    input  logic              cmd_latch,
    input  logic              addr_latch,
    input  cmd_class_e        cls,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [ADDR_W-1:0] addr_nx,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic              clr_all,
    output logic              clr_col,
    output logic              clr_cnt,
    output logic              erase_fix,
    output logic              byte_en,
    output seq_state_e        state_q,
    output logic              op_valid,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [OFF_W-1:0]  col_offset
);
    seq_state_e       state_nx;
    logic [OFF_W-1:0] off_nx;
    logic             fire;
    op_kind_e         kind_nx;
    logic             use_nx;
    logic             cmd_we, adr_we, ignore_conf, rand_col;

    assign cmd_we      = wr_strobe && !chip_sel_n && cmd_latch;
    assign adr_we      = wr_strobe && !chip_sel_n && addr_latch && !cmd_latch;
    assign ignore_conf = LARGE_PAGE && (state_q == ST_READ) && (cls == CL_READ_CONFIRM);
    assign rand_col    = LARGE_PAGE && (cls == CL_RAND_COL);

    always_comb begin
        state_nx  = state_q;
        off_nx    = col_offset;
        fire      = 1'b0;
        kind_nx   = OP_NONE;
        use_nx    = 1'b0;
        clr_all   = 1'b0;
        clr_col   = 1'b0;
        clr_cnt   = 1'b0;
        erase_fix = 1'b0;
        byte_en   = 1'b0;
        if (cmd_we && !ignore_conf) begin
            if (rand_col) begin
                clr_col = 1'b1;
            end else begin
                clr_cnt = (cls != CL_RAND_CONFIRM);
                unique case (cls)
                    CL_READ_A: begin
                        state_nx = ST_READ;
                        off_nx   = '0;
                    end
                    CL_READ_B: begin
                        state_nx = ST_READ;
                        off_nx   = OFF_W'(256);
                    end
                    CL_READ_C: begin
                        state_nx = ST_READ;
                        off_nx   = OFF_W'(PAGE_BYTES);
                    end
                    CL_PROG_SETUP:  state_nx = ST_PROGRAM;
                    CL_ERASE_SETUP: state_nx = ST_ERASE;
                    CL_READ_ID:     state_nx = ST_READ_ID;
                    CL_COPYBACK:    state_nx = ST_COPYBACK;
                    CL_STATUS: begin
                        state_nx = ST_STATUS;
                        fire     = 1'b1;
                        kind_nx  = OP_STATUS;
                    end
                    CL_PROG_CONFIRM: begin
                        state_nx = ST_OTHER;
                        fire     = 1'b1;
                        kind_nx  = OP_PROGRAM;
                    end
                    CL_ERASE_CONFIRM: begin
                        state_nx  = ST_OTHER;
                        erase_fix = 1'b1;
                        fire      = 1'b1;
                        kind_nx   = OP_ERASE;
                        use_nx    = 1'b1;
                    end
                    CL_NOSER_CONFIRM, CL_RAND_CONFIRM: begin
                        state_nx = ST_OTHER;
                        fire     = LARGE_PAGE;
                        kind_nx  = LARGE_PAGE ? OP_LOAD : OP_NONE;
                    end
                    CL_RESET: begin
                        state_nx = ST_READ;
                        off_nx   = '0;
                        clr_all  = 1'b1;
                        fire     = 1'b1;
                        kind_nx  = OP_RESET;
                        use_nx   = 1'b1;
                    end
                    default: state_nx = ST_OTHER;
                endcase
            end
        end else if (adr_we) begin
            byte_en = 1'b1;
            use_nx  = 1'b1;
            if (cnt_q < CNT_W'(ADDR_BYTES)) begin
                if ((state_q == ST_READ_ID) && (cnt_q == '0)) begin
                    fire    = 1'b1;
                    kind_nx = OP_ID;
                end
                if (cnt_q == CNT_W'(START_CYC - 1)) begin
                    if (state_q == ST_READ) begin
                        fire    = 1'b1;
                        kind_nx = OP_LOAD;
                    end else if (state_q == ST_PROGRAM) begin
                        fire    = 1'b1;
                        kind_nx = OP_PROG_SETUP;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_valid   <= 1'b0;
            op_kind    <= OP_NONE;
            op_addr    <= '0;
            col_offset <= '0;
        end else begin
            op_valid   <= fire;
            op_kind    <= kind_nx;
            col_offset <= off_nx;
            if (fire) op_addr <= use_nx ? addr_nx : addr_q;
        end
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter bit  LARGE_PAGE = 1'b1,
    parameter bit  BIG_DEVICE = 1'b0,
    parameter bit  WIDE_BUS   = 1'b0,
    parameter int  ADDR_BYTES = 5,
    parameter int  PAGE_BYTES = 2048,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1),
    localparam int OFF_W      = $clog2(PAGE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic              chip_sel_n,
    input  logic              cmd_latch,
    input  logic              addr_latch,
    input  logic [7:0]        bus_in,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [OFF_W-1:0]  col_offset,
    output logic [2:0]        cmd_state,
    output logic [CNT_W-1:0]  addr_count
);
    localparam int COL_BITS  = LARGE_PAGE ? 16 : 8;
    localparam int START_CYC = !LARGE_PAGE ? 3 : (BIG_DEVICE ? 5 : 4);

    cmd_class_e        cls;
    seq_state_e        state_q;
    op_kind_e          kind_q;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic              clr_all, clr_col, clr_cnt, erase_fix, byte_en;

    nand_opcode_decode u_decode (
        .opcode (bus_in),
        .cls    (cls)
    );

    nand_addr_reg #(
        .ADDR_BYTES (ADDR_BYTES),
        .COL_BITS   (COL_BITS),
        .ROW_SHIFT  (COL_BITS),
        .WIDE_BUS   (WIDE_BUS)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .clr_col   (clr_col),
        .clr_cnt   (clr_cnt),
        .erase_fix (erase_fix),
        .byte_en   (byte_en),
        .byte_in   (bus_in),
        .addr_q    (addr_q),
        .addr_nx   (addr_nx),
        .cnt_q     (addr_count)
    );

    nand_seq_fsm #(
        .LARGE_PAGE (LARGE_PAGE),
        .ADDR_BYTES (ADDR_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .START_CYC  (START_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe  (wr_strobe),
        .chip_sel_n (chip_sel_n),
        .cmd_latch  (cmd_latch),
        .addr_latch (addr_latch),
        .cls        (cls),
        .addr_q     (addr_q),
        .addr_nx    (addr_nx),
        .cnt_q      (addr_count),
        .clr_all    (clr_all),
        .clr_col    (clr_col),
        .clr_cnt    (clr_cnt),
        .erase_fix  (erase_fix),
        .byte_en    (byte_en),
        .state_q    (state_q),
        .op_valid   (op_valid),
        .op_kind    (kind_q),
        .op_addr    (op_addr),
        .col_offset (col_offset)
    );

    assign cmd_state = state_q;
    assign op_kind   = kind_q;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
    parameter bit LARGE_PAGE = 1'b1,
    parameter int ADDR_BYTES = 5,
    parameter int CNT_W      = 3,
    parameter int OFF_W      = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_strobe,
    input logic             chip_sel_n,
    input logic             cmd_latch,
    input logic             addr_latch,
    input logic [7:0]       bus_in,
    input logic             op_valid,
    input logic [2:0]       op_kind,
    input logic [OFF_W-1:0] col_offset,
    input logic [2:0]       cmd_state,
    input logic [CNT_W-1:0] addr_count
);
    logic take_cmd, take_adr;
    assign take_cmd = wr_strobe && !chip_sel_n && cmd_latch;
    assign take_adr = wr_strobe && !chip_sel_n && addr_latch && !cmd_latch;

    AST_DESELECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && chip_sel_n) |=> (!op_valid && $stable(cmd_state) && $stable(addr_count) && $stable(col_offset))); // R1

    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && !chip_sel_n) |=> !op_valid); // R13

    AST_READ_B_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cmd && bus_in == 8'h01) |=> (cmd_state == 3'd0 && col_offset == OFF_W'(256))); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (take_adr && addr_count < CNT_W'(ADDR_BYTES)) |=> (addr_count == $past(addr_count) + 1'b1)); // R6

    AST_RESET_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cmd && bus_in == 8'hFF) |=> (op_valid && op_kind == 3'd7 && cmd_state == 3'd0 && addr_count == '0 && col_offset == '0)); // R12

    AST_COL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (LARGE_PAGE && take_cmd && bus_in == 8'h05) |=> (addr_count == '0 && $stable(cmd_state) && !op_valid)); // R5
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(
    .LARGE_PAGE (LARGE_PAGE),
    .ADDR_BYTES (ADDR_BYTES),
    .CNT_W      (CNT_W),
    .OFF_W      (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_strobe  (wr_strobe),
    .chip_sel_n (chip_sel_n),
    .cmd_latch  (cmd_latch),
    .addr_latch (addr_latch),
    .bus_in     (bus_in),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .col_offset (col_offset),
    .cmd_state  (cmd_state),
    .addr_count (addr_count)
);

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_strobe = 1'b0, chip_sel_n = 1'b1, cmd_latch = 1'b0, addr_latch = 1'b0;
    logic [7:0] bus_in = 8'h00;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    // default instance: large page, 1 Gbit class, 8-bit bus (start on byte 4)
    logic        lv; logic [2:0] lk; logic [39:0] la; logic [11:0] lo; logic [2:0] ls; logic [2:0] lc;
    nand_cmd_seq i_nand_cmd_seq (.clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .chip_sel_n(chip_sel_n),
        .cmd_latch(cmd_latch), .addr_latch(addr_latch), .bus_in(bus_in), .op_valid(lv), .op_kind(lk),
        .op_addr(la), .col_offset(lo), .cmd_state(ls), .addr_count(lc));

    // small page, 16-bit bus (start on byte 3)
    logic        sv; logic [2:0] sk; logic [39:0] sa; logic [9:0] so; logic [2:0] ss; logic [2:0] sc;
    nand_cmd_seq #(.LARGE_PAGE(1'b0), .WIDE_BUS(1'b1), .PAGE_BYTES(512)) i_nand_cmd_seq_sp (.clk(clk),
        .rst_n(rst_n), .wr_strobe(wr_strobe), .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch),
        .addr_latch(addr_latch), .bus_in(bus_in), .op_valid(sv), .op_kind(sk), .op_addr(sa),
        .col_offset(so), .cmd_state(ss), .addr_count(sc));

    // large page, 2 Gbit class (start on byte 5)
    logic        bv; logic [2:0] bk; logic [39:0] ba; logic [11:0] bo; logic [2:0] bs; logic [2:0] bc;
    nand_cmd_seq #(.BIG_DEVICE(1'b1)) i_nand_cmd_seq_big (.clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe),
        .chip_sel_n(chip_sel_n), .cmd_latch(cmd_latch), .addr_latch(addr_latch), .bus_in(bus_in),
        .op_valid(bv), .op_kind(bk), .op_addr(ba), .col_offset(bo), .cmd_state(bs), .addr_count(bc));

    typedef struct packed {
        logic        cs_n, cl, al;
        logic [7:0]  b;
        logic        vld;
        logic [2:0]  kind, st, cnt;
        logic [39:0] addr;
    } vec_t;

    localparam vec_t VEC [28] = '{
        '{1'b0,1'b1,1'b0,8'h00, 1'b0,3'd0,3'd0,3'd0,40'h0},
        '{1'b0,1'b0,1'b1,8'h11, 1'b0,3'd0,3'd0,3'd1,40'h0},
        '{1'b0,1'b0,1'b1,8'h22, 1'b0,3'd0,3'd0,3'd2,40'h0},
        '{1'b0,1'b0,1'b1,8'h33, 1'b0,3'd0,3'd0,3'd3,40'h0},
        '{1'b0,1'b0,1'b1,8'h44, 1'b1,3'd1,3'd0,3'd4,40'h0044332211}, // R9 byte 4
        '{1'b0,1'b1,1'b0,8'h30, 1'b0,3'd0,3'd0,3'd4,40'h0},          // R4 ignored
        '{1'b0,1'b1,1'b0,8'h05, 1'b0,3'd0,3'd0,3'd0,40'h0},          // R5
        '{1'b0,1'b0,1'b1,8'h78, 1'b0,3'd0,3'd0,3'd1,40'h0},
        '{1'b0,1'b0,1'b1,8'h56, 1'b0,3'd0,3'd0,3'd2,40'h0},
        '{1'b0,1'b1,1'b0,8'hE0, 1'b1,3'd1,3'd6,3'd2,40'h0044335678}, // R7 keeps count, R5 column
        '{1'b0,1'b1,1'b0,8'h90, 1'b0,3'd0,3'd3,3'd0,40'h0},
        '{1'b0,1'b0,1'b1,8'h00, 1'b1,3'd6,3'd3,3'd1,40'h0044335600}, // R8
        '{1'b0,1'b1,1'b0,8'h70, 1'b1,3'd5,3'd4,3'd0,40'h0044335600},
        '{1'b1,1'b1,1'b0,8'h00, 1'b0,3'd0,3'd4,3'd0,40'h0},          // R1 deselected
        '{1'b0,1'b1,1'b0,8'h60, 1'b0,3'd0,3'd2,3'd0,40'h0},
        '{1'b0,1'b0,1'b1,8'h05, 1'b0,3'd0,3'd2,3'd1,40'h0},
        '{1'b0,1'b0,1'b1,8'h06, 1'b0,3'd0,3'd2,3'd2,40'h0},
        '{1'b0,1'b0,1'b1,8'h07, 1'b0,3'd0,3'd2,3'd3,40'h0},
        '{1'b0,1'b1,1'b0,8'hD0, 1'b1,3'd4,3'd6,3'd0,40'h0706050000}, // R11
        '{1'b0,1'b1,1'b0,8'h80, 1'b0,3'd0,3'd1,3'd0,40'h0},
        '{1'b0,1'b0,1'b1,8'hA1, 1'b0,3'd0,3'd1,3'd1,40'h0},
        '{1'b0,1'b0,1'b1,8'hB2, 1'b0,3'd0,3'd1,3'd2,40'h0},
        '{1'b0,1'b0,1'b1,8'hC3, 1'b0,3'd0,3'd1,3'd3,40'h0},
        '{1'b0,1'b0,1'b1,8'hD4, 1'b1,3'd2,3'd1,3'd4,40'h07D4C3B2A1}, // R9 program
        '{1'b0,1'b0,1'b0,8'h99, 1'b0,3'd0,3'd1,3'd4,40'h0},          // data byte
        '{1'b0,1'b1,1'b0,8'h10, 1'b1,3'd3,3'd6,3'd0,40'h07D4C3B2A1},
        '{1'b0,1'b1,1'b1,8'h70, 1'b1,3'd5,3'd4,3'd0,40'h07D4C3B2A1}, // R2 both latches
        '{1'b0,1'b1,1'b0,8'hFF, 1'b1,3'd7,3'd0,3'd0,40'h0}           // R12
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic cs_n, input logic cl, input logic al, input logic [7:0] b);
        @(negedge clk);
        chip_sel_n = cs_n; cmd_latch = cl; addr_latch = al; bus_in = b; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0; cmd_latch = 1'b0; addr_latch = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R12", "reset valid", 64'(lv), 64'd0);
        check("R12", "reset state", 64'(ls), 64'd0);
        check("R12", "reset count", 64'(lc), 64'd0);
        check("R12", "reset offset", 64'(lo), 64'd0);

        for (int i = 0; i < 28; i++) begin
            put(VEC[i].cs_n, VEC[i].cl, VEC[i].al, VEC[i].b);
            check("R13", $sformatf("vec %0d valid", i), 64'(lv), 64'(VEC[i].vld));
            check("R2",  $sformatf("vec %0d state", i), 64'(ls), 64'(VEC[i].st));
            check("R6",  $sformatf("vec %0d count", i), 64'(lc), 64'(VEC[i].cnt));
            if (VEC[i].vld) begin
                check("R7", $sformatf("vec %0d kind", i), 64'(lk), 64'(VEC[i].kind));
                check("R7", $sformatf("vec %0d addr", i), 64'(la), 64'(VEC[i].addr));
            end
        end

        // R3 read variants and offsets
        put(1'b0, 1'b1, 1'b0, 8'h01);
        check("R3", "0x01 offset", 64'(lo), 64'h100);
        put(1'b0, 1'b1, 1'b0, 8'h70);
        check("R3", "offset kept", 64'(lo), 64'h100);
        put(1'b0, 1'b1, 1'b0, 8'h50);
        check("R3", "0x50 offset large", 64'(lo), 64'd2048);
        check("R3", "0x50 offset small", 64'(so), 64'd512);
        check("R3", "0x50 state", 64'(ls), 64'd0);
        put(1'b0, 1'b1, 1'b0, 8'h00);
        check("R3", "0x00 offset", 64'(lo), 64'd0);

        // R9 start cycle per geometry, R10 wide-bus shift
        do_reset();
        put(1'b0, 1'b1, 1'b0, 8'h00);
        put(1'b0, 1'b0, 1'b1, 8'h12);
        put(1'b0, 1'b0, 1'b1, 8'h34);
        check("R9", "small no pulse at 2", 64'(sv), 64'd0);
        put(1'b0, 1'b0, 1'b1, 8'h56);
        check("R9", "small pulse at 3", 64'(sv), 64'd1);
        check("R9", "small kind", 64'(sk), 64'd1);
        check("R10", "small shifted addr", 64'(sa), 64'h566824);
        check("R9", "large no pulse at 3", 64'(lv), 64'd0);
        put(1'b0, 1'b0, 1'b1, 8'h78);
        check("R9", "large pulse at 4", 64'(lv), 64'd1);
        check("R9", "large addr", 64'(la), 64'h78563412);
        check("R9", "big no pulse at 4", 64'(bv), 64'd0);
        check("R9", "small no pulse at 4", 64'(sv), 64'd0);
        put(1'b0, 1'b0, 1'b1, 8'h9A);
        check("R9", "big pulse at 5", 64'(bv), 64'd1);
        check("R9", "big addr", 64'(ba), 64'h9A78563412);
        check("R13", "large silent at 5", 64'(lv), 64'd0);

        // R11 erase row forming for both shifts
        put(1'b0, 1'b1, 1'b0, 8'h60);
        put(1'b0, 1'b0, 1'b1, 8'h01);
        put(1'b0, 1'b0, 1'b1, 8'h02);
        put(1'b0, 1'b1, 1'b0, 8'hD0);
        check("R11", "large erase kind", 64'(lk), 64'd4);
        check("R11", "large erase row", 64'(la), 64'h0201_0000);
        check("R11", "small erase row", 64'(sa), 64'h040200);

        // R6 saturation
        put(1'b0, 1'b1, 1'b0, 8'h60);
        for (int j = 0; j < 6; j++) put(1'b0, 1'b0, 1'b1, 8'(j + 1));
        check("R6", "count saturates", 64'(lc), 64'd5);

        // R4 in small page: 0x30 is not ignored there
        put(1'b0, 1'b1, 1'b0, 8'h00);
        put(1'b0, 1'b1, 1'b0, 8'h30);
        check("R4", "small 0x30 leaves read", 64'(ss), 64'd6);
        check("R4", "large 0x30 stays read", 64'(ls), 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule